// File: doc/BRIEF.md
# Power-Fail Protected Byte-Wide Static Memory

This block models an 8192 x 8 static memory whose control port behaves like an asynchronous part but is sampled on a fast system clock. Active-low chip-enable, write-enable and output-enable, a 13-bit address and a bidirectional data bus set up read and write cycles. Every interval is counted in clock cycles.

A write runs for as long as chip-enable and write-enable are both low. It stores the byte that was on the bus in the last sample before either control returned high. After each write the port enforces a recovery interval. During that interval reads stay floating and write attempts are refused and flagged. Each cycle begins with an edge, so a refused attempt stays refused until its controls are released.

Three threshold flags from an outside comparator report the supply level. A state machine follows them through three modes: normal, write-protected and battery backup. Outside normal mode the port ignores every control and floats the bus, and a write already in progress is discarded. Normal operation returns only when the highest flag is set, which gives the thresholds hysteresis.

Top module: `guarded_sram`

## Requirements
- R1: While reset is held, `supplyMode` reads 2'b01 (protected), `recoveryViolation` is 0 and the data bus is not driven.
- R2: A write begins at the first sample with `ceN` and `weN` both low and latches the address at that sample. When `weN` returns high, the byte sampled on `dataIo` at the last both-low sample is stored at the latched address.
- R3: A write that ends when `ceN` returns high, with `weN` still low, stores its byte in the same way as R2.
- R4: A sample with `ceN` low, `weN` high and `oeN` low drives the addressed byte on `dataIo` one cycle later. With `ceN` high or `oeN` high the bus is left floating.
- R5: For the `REC_CYCLES` samples after the commit edge, reads float. A write attempt in that window stores nothing and pulses `recoveryViolation` for one cycle. That attempt stays ignored until `ceN` or `weN` is released, even if the window ends while it is held.
- R6: A sample in normal mode with `aboveProt` low moves the block to protected mode on that edge. Outside normal mode, reads float and writes store nothing.
- R7: A sample with `aboveBackup` low moves the block to backup (2'b10). It leaves backup for protected mode once `aboveBackup` is high again. Stored bytes survive the round trip.
- R8: Protected mode returns to normal (2'b00) only on a sample with `aboveOper` high. Backup never goes straight to normal.
- R9: A write in progress when protection takes effect is aborted, and the addressed byte keeps its old value.
- R10: `supplyMode` uses 2'b00 for normal, 2'b01 for protected and 2'b10 for backup, and never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every control |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 13 | Byte address |
| dataIo | inout | 8 | Bidirectional data bus |
| aboveOper | input | 1 | Supply is above the full operating level |
| aboveProt | input | 1 | Supply is above the write-protect threshold |
| aboveBackup | input | 1 | Supply is above the backup switch-over level |
| supplyMode | output | 2 | Current supply mode (see R10) |
| recoveryViolation | output | 1 | One-cycle pulse on a write attempt refused during recovery |

## Verification
The bench sends a write attempt straight after a commit and keeps it held past the end of the recovery window. A design that restarted the write once the window ended would overwrite the byte. A design without the window would store the byte at once and raise no violation pulse. It also drops the supply partway through a write. A design that committed on abort would corrupt the byte, and one that kept driving while locked out would show data where the pulled-up bus should read all ones. Raising the flags only to the protect level checks that the block stays locked out, and raising all of them at once from backup checks that it passes through protected mode on the way to normal.

// File: rtl/guarded_sram_pkg.sv
package guarded_sram_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_LOCK = 2'b01,
    MODE_HOLD = 2'b10
  } supplyMode_e;

  typedef struct packed {
    logic startWr;
    logic holdWr;
    logic commitWr;
    logic readEn;
  } memStrobe_t;
endpackage

// File: rtl/guarded_sram_ctrl.sv
module guarded_sram_ctrl
  import guarded_sram_pkg::*;
#(
  parameter int REC_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  input  logic        aboveOper,
  input  logic        aboveProt,
  input  logic        aboveBackup,
  output memStrobe_t  strobe,
  output supplyMode_e mode,
  output logic        violation
);
  localparam int CNT_W = $clog2(REC_CYCLES + 1);

  supplyMode_e      modeQ, modeNext;
  logic [CNT_W-1:0] recCnt;
  logic             writingQ, blockedQ;
  logic             gate, bothLow, idle, startOk, attempt;

  // Supply-state machine: exits from backup and protected mode are ordered.
  always_comb begin
    case (modeQ)
      MODE_RUN:  modeNext = !aboveBackup ? MODE_HOLD :
                            (!aboveProt ? MODE_LOCK : MODE_RUN);
      MODE_LOCK: modeNext = !aboveBackup ? MODE_HOLD :
                            (aboveOper ? MODE_RUN : MODE_LOCK);
      MODE_HOLD: modeNext = aboveBackup ? MODE_LOCK : MODE_HOLD;
      default:   modeNext = MODE_LOCK;
    endcase
  end

  always_comb begin
    gate    = (modeNext == MODE_RUN);
    bothLow = !ceN && !weN;
    idle    = (recCnt == '0);
    startOk = gate && bothLow && !writingQ && !blockedQ && idle;
    attempt = gate && bothLow && !writingQ && !blockedQ && !idle;
    strobe.startWr  = startOk;
    strobe.holdWr   = gate && bothLow && writingQ;
    strobe.commitWr = gate && writingQ && !bothLow;
    strobe.readEn   = gate && !ceN && weN && !oeN && idle && !writingQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_LOCK;
      writingQ  <= 1'b0;
      blockedQ  <= 1'b0;
      violation <= 1'b0;
      recCnt    <= '0;
    end else begin
      modeQ     <= modeNext;
      writingQ  <= gate && (startOk || (writingQ && bothLow));
      blockedQ  <= attempt || (blockedQ && bothLow);
      violation <= attempt;
      if (strobe.commitWr) recCnt <= CNT_W'(REC_CYCLES);
      else if (!idle)      recCnt <= recCnt - 1'b1;
    end
  end

  assign mode = modeQ;
endmodule

// File: rtl/guarded_sram_datapath.sv
module guarded_sram_datapath
  import guarded_sram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              busDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (strobe.startWr) begin
      addrQ <= addr;
      dataQ <= dataIn;
    end else if (strobe.holdWr) begin
      dataQ <= dataIn;
    end
    if (strobe.commitWr) mem[addrQ] <= dataQ;
    if (strobe.readEn)   rdData     <= mem[addr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busDrive <= 1'b0;
    else       busDrive <= strobe.readEn;
  end
endmodule

// File: rtl/guarded_sram.sv
module guarded_sram
  import guarded_sram_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int REC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dataIo,
  input  logic              aboveOper,
  input  logic              aboveProt,
  input  logic              aboveBackup,
  output logic [1:0]        supplyMode,
  output logic              recoveryViolation
);
  memStrobe_t        strobe;
  supplyMode_e       mode;
  logic [DATA_W-1:0] rdData;
  logic              busDrive;

  guarded_sram_ctrl #(.REC_CYCLES(REC_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .aboveOper(aboveOper), .aboveProt(aboveProt), .aboveBackup(aboveBackup),
    .strobe(strobe), .mode(mode), .violation(recoveryViolation)
  );

  guarded_sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .dataIn(dataIo),
    .rdData(rdData), .busDrive(busDrive)
  );

  assign dataIo     = busDrive ? rdData : {DATA_W{1'bz}};
  assign supplyMode = mode;
endmodule

// File: rtl/guarded_sram_chk.sv
module guarded_sram_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       weN,
  input logic       oeN,
  input logic       aboveOper,
  input logic       aboveProt,
  input logic       aboveBackup,
  input logic [1:0] supplyMode,
  input logic       recoveryViolation,
  input logic       busDrive
);
  assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rstN)
    supplyMode != 2'b11);

  assert_drop_leaves_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    (supplyMode == 2'b00 && !aboveProt) |=> supplyMode != 2'b00);

  assert_no_drive_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (supplyMode != 2'b00) |-> !busDrive);

  assert_hysteresis_R8: assert property (@(posedge clk) disable iff (!rstN)
    (supplyMode == 2'b01 && !aboveOper) |=> supplyMode != 2'b00);

  assert_backup_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (supplyMode == 2'b10) |=> supplyMode != 2'b00);

  assert_drive_needs_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> $past(!ceN && weN && !oeN));

  assert_violation_in_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    recoveryViolation |-> supplyMode == 2'b00);
endmodule

bind guarded_sram guarded_sram_chk chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
  .aboveOper(aboveOper), .aboveProt(aboveProt), .aboveBackup(aboveBackup),
  .supplyMode(supplyMode), .recoveryViolation(recoveryViolation),
  .busDrive(busDrive)
);

// File: tb/guarded_sram_test.sv
module guarded_sram_test;
  localparam int REC = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [12:0] addr = '0;
  logic        aboveOper = 1'b1, aboveProt = 1'b1, aboveBackup = 1'b1;
  logic [7:0]  tbData = '0;
  logic        tbDrive = 1'b0;
  wire  [7:0]  dataIo;
  logic [1:0]  supplyMode;
  logic        recoveryViolation;
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign dataIo = tbDrive ? tbData : 8'hzz;
  for (genvar i = 0; i < 8; i++) begin : g_pull
    pullup (dataIo[i]);
  end

  guarded_sram #(.ADDR_W(13), .DATA_W(8), .REC_CYCLES(REC)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIo(dataIo), .aboveOper(aboveOper), .aboveProt(aboveProt),
    .aboveBackup(aboveBackup), .supplyMode(supplyMode),
    .recoveryViolation(recoveryViolation)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Two both-low samples, then end by WE or CE; waits out recovery.
  task automatic writeByte(logic [12:0] a, logic [7:0] d, bit byCe);
    addr = a; tbData = d; tbDrive = 1'b1; ceN = 1'b0; weN = 1'b0;
    tick(); tick();
    if (byCe) ceN = 1'b1; else weN = 1'b1;
    tick();
    ceN = 1'b1; weN = 1'b1; tbDrive = 1'b0;
    repeat (REC + 1) tick();
  endtask

  task automatic readByte(logic [12:0] a, output logic [7:0] d);
    addr = a; ceN = 1'b0; weN = 1'b1; oeN = 1'b0;
    tick();
    d = dataIo;
    ceN = 1'b1; oeN = 1'b1;
    tick();
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    tick();
    check("R1 mode", {6'd0, supplyMode}, 8'h01);
    check("R1 violation", {7'd0, recoveryViolation}, 8'h00);
    check("R1 bus floats", dataIo, 8'hFF);
    rstN = 1'b1;
    tick();
    check("R10 normal code", {6'd0, supplyMode}, 8'h00);
  endtask

  task automatic testWrites();
    logic [7:0] d;
    writeByte(13'h0010, 8'h5A, 1'b0);
    readByte(13'h0010, d);  check("R2 WE-ended write", d, 8'h5A);
    writeByte(13'h1FFF, 8'hC3, 1'b1);
    readByte(13'h1FFF, d);  check("R3 CE-ended write", d, 8'hC3);
    writeByte(13'h0000, 8'h11, 1'b0);
    writeByte(13'h0ABC, 8'h22, 1'b1);
    writeByte(13'h1234, 8'h33, 1'b0);
    readByte(13'h0000, d);  check("R2 address zero", d, 8'h11);
  endtask

  task automatic testReadGating();
    addr = 13'h0010; ceN = 1'b0; weN = 1'b1; oeN = 1'b1;
    tick(); check("R4 oeN high floats", dataIo, 8'hFF);
    ceN = 1'b1; oeN = 1'b0;
    tick(); check("R4 ceN high floats", dataIo, 8'hFF);
    ceN = 1'b0;
    tick(); check("R4 read drives", dataIo, 8'h5A);
    ceN = 1'b1; oeN = 1'b1;
    tick(); check("R4 release floats", dataIo, 8'hFF);
  endtask

  task automatic testRecovery();
    logic [7:0] d;
    addr = 13'h0040; tbData = 8'h5C; tbDrive = 1'b1; ceN = 1'b0; weN = 1'b0;
    tick(); tick();
    weN = 1'b1;
    tick();                       // commit edge passed
    tbDrive = 1'b0; oeN = 1'b0;   // read at once
    tick(); check("R5 read in recovery floats", dataIo, 8'hFF);
    oeN = 1'b1; addr = 13'h0000; tbData = 8'hEE; tbDrive = 1'b1; weN = 1'b0;
    tick(); check("R5 violation pulse", {7'd0, recoveryViolation}, 8'h01);
    tick(); check("R5 pulse is one cycle", {7'd0, recoveryViolation}, 8'h00);
    repeat (REC + 2) tick();      // hold past the end of the window
    check("R5 no repeat pulse", {7'd0, recoveryViolation}, 8'h00);
    ceN = 1'b1; weN = 1'b1; tbDrive = 1'b0;
    tick();
    readByte(13'h0000, d); check("R5 refused write kept old byte", d, 8'h11);
    readByte(13'h0040, d); check("R2 byte before recovery", d, 8'h5C);
  endtask

  task automatic testProtect();
    logic [7:0] d;
    aboveProt = 1'b0; aboveOper = 1'b0;
    tick(); check("R6 protected mode", {6'd0, supplyMode}, 8'h01);
    readByte(13'h0ABC, d); check("R6 read floats", d, 8'hFF);
    writeByte(13'h0ABC, 8'h99, 1'b0);
    aboveProt = 1'b1;
    tick(); tick(); check("R8 stays protected", {6'd0, supplyMode}, 8'h01);
    aboveOper = 1'b1;
    tick(); check("R8 resumes normal", {6'd0, supplyMode}, 8'h00);
    readByte(13'h0ABC, d); check("R6 locked write ignored", d, 8'h22);
  endtask

  task automatic testBackup();
    logic [7:0] d;
    aboveOper = 1'b0; aboveProt = 1'b0; aboveBackup = 1'b0;
    tick(); check("R7 enters backup", {6'd0, supplyMode}, 8'h02);
    aboveBackup = 1'b1;
    tick(); check("R7 leaves to protected", {6'd0, supplyMode}, 8'h01);
    aboveProt = 1'b1; aboveOper = 1'b1;
    tick(); check("R8 normal after protected", {6'd0, supplyMode}, 8'h00);
    aboveOper = 1'b0; aboveProt = 1'b0; aboveBackup = 1'b0;
    tick(); check("R7 backup again", {6'd0, supplyMode}, 8'h02);
    aboveOper = 1'b1; aboveProt = 1'b1; aboveBackup = 1'b1;
    tick(); check("R8 backup passes protected", {6'd0, supplyMode}, 8'h01);
    tick(); check("R8 then normal", {6'd0, supplyMode}, 8'h00);
    readByte(13'h0010, d); check("R7 data retained", d, 8'h5A);
  endtask

  task automatic testAbort();
    logic [7:0] d;
    addr = 13'h1234; tbData = 8'h77; tbDrive = 1'b1; ceN = 1'b0; weN = 1'b0;
    tick(); tick();
    aboveProt = 1'b0; aboveOper = 1'b0;
    tick();
    ceN = 1'b1; weN = 1'b1; tbDrive = 1'b0;
    tick();
    aboveProt = 1'b1; aboveOper = 1'b1;
    tick(); tick();
    check("R9 back to normal", {6'd0, supplyMode}, 8'h00);
    check("R9 no violation", {7'd0, recoveryViolation}, 8'h00);
    readByte(13'h1234, d); check("R9 aborted write", d, 8'h33);
  endtask

  initial begin
    tick();
    testReset();
    testWrites();
    testReadGating();
    testRecovery();
    testProtect();
    testBackup();
    testAbort();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule